// File: doc/BRIEF.md
# DRAM Row/Column Access Sequencer

This block sequences accesses to a single DRAM bank. Each request carries a flat address. The block splits that address into a row part and a column part and drives them, one after the other, onto a shared address bus. A row strobe marks the row phase and a column strobe marks the column phase.

The block remembers which row is open in the bank's row buffer and treats it as a one-line cache:
- A request to the open row gets only a column access.
- A request to a different row first closes the open row with a precharge, then activates the new row, then does the column access.
- A request that finds no row open starts directly with the activation.

A free-running interval timer raises a refresh request at a fixed period. The refresh is taken between requests. It closes any open row, activates the row named by a wrapping refresh pointer, and closes that row again.

Top module: `dram_seq`

## Requirements
- R1: During and directly after reset, `rq_ready` is 1, `row_stb`, `col_stb`, `pre_stb` and `acc_done` are 0, and `mem_addr` is 0.
- R2: The request address splits as row = `rq_addr[ADDR_W-1:COL_W]` and column = `rq_addr[COL_W-1:0]`. Both are zero-extended onto `mem_addr`. The row appears in the cycle of `row_stb` and the column in the cycle of `col_stb`. In all other cycles `mem_addr` is 0.
- R3: When no row is open, an accepted request gives `row_stb` in the cycle after acceptance, `col_stb` exactly `T_RCD` cycles later, and no `pre_stb`.
- R4: A request whose row equals the open row gives only `col_stb`, in the cycle after acceptance. It gives no `row_stb` and no `pre_stb`.
- R5: A request to a row other than the open one gives `pre_stb` in the cycle after acceptance, `row_stb` `T_RP` cycles after that, and `col_stb` `T_RCD` cycles after `row_stb`.
- R6: `acc_done` is high for exactly the one cycle of `col_stb`. `rq_ready` is low from the cycle after acceptance through the `col_stb` cycle, and is high again in the following cycle.
- R7: `rq_valid` is ignored while `rq_ready` is low. A valid pulse during a busy period produces no strobe afterwards.
- R8: A refresh is requested every `RFSH_PERIOD` cycles and is taken only when the block is idle; `rq_ready` is low while it is pending. A refresh does the following:
  - If a row is open, it issues `pre_stb` and waits `T_RP` cycles.
  - It issues `row_stb` with the refresh pointer on `mem_addr`.
  - It issues `pre_stb` `T_RCD` cycles after that `row_stb`.
  - It raises `rq_ready` `T_RP` cycles after the closing `pre_stb`.
  - It leaves no row open.
- R9: The refresh pointer starts at 0, advances by one per refresh and wraps modulo 2^ROW_W.
- R10: At most one of `row_stb`, `col_stb`, `pre_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Request present |
| rq_addr | input | ROW_W+COL_W | Request address, row in upper bits |
| rq_ready | output | 1 | Request is taken on this cycle if valid |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address bus |
| row_stb | output | 1 | Row activate strobe |
| col_stb | output | 1 | Column access strobe |
| pre_stb | output | 1 | Precharge (close row) strobe |
| acc_done | output | 1 | Column access finished |

## Verification
The bench builds the block with ROW_W=8, COL_W=10, T_RCD=3, T_RP=2 and RFSH_PERIOD=64:
- The unequal activate and precharge gaps expose any swap of the two delays.
- The unequal row and column widths expose a wrong split point on the bus.
- The short refresh period and eight-bit pointer bring a full pointer wrap, and repeated refresh intervals, within about seventeen thousand cycles.

Every directed request finishes inside the quiet window between two refreshes, so each strobe can be checked against an exact cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_ACT,
      S_COL,
      S_WAIT,
      S_RF_ACT,
      S_RF_CLS
   } seq_st_t;

   localparam int GAP_W = 8;
endpackage

// File: rtl/dram_rfsh_ctl.sv
module dram_rfsh_ctl #(
   parameter int PERIOD = 512,
   parameter int PTR_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant,
   input  logic             step,
   output logic             pending,
   output logic [PTR_W-1:0] ptr
);
   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("dram_rfsh_ctl: PERIOD must be at least 2");
   end

   logic [CNT_W-1:0] tick;
   logic             wrap;

   assign wrap = (tick == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick    <= '0;
         pending <= 1'b0;
         ptr     <= '0;
      end else begin
         tick    <= wrap ? '0 : tick + 1'b1;
         pending <= wrap | (pending & ~grant);
         if (step) ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             close,
   input  logic [ROW_W-1:0] act_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             open_vld,
   output logic             hit
);
   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_vld <= 1'b0;
         open_row <= '0;
      end else if (act) begin
         open_vld <= 1'b1;
         open_row <= act_row;
      end else if (close) begin
         open_vld <= 1'b0;
      end
   end

   assign hit = open_vld && (open_row == cmp_row);

   // R5: a new row is only activated after the previous one was closed
   assert_act_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> !open_vld);
endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
   parameter int ROW_W       = 12,
   parameter int COL_W       = 12,
   parameter int T_RCD       = 3,
   parameter int T_RP        = 3,
   parameter int RFSH_PERIOD = 512,
   localparam int ADDR_W     = ROW_W + COL_W,
   localparam int BUS_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rq_valid,
   input  logic [ADDR_W-1:0] rq_addr,
   output logic              rq_ready,
   output logic [BUS_W-1:0]  mem_addr,
   output logic              row_stb,
   output logic              col_stb,
   output logic              pre_stb,
   output logic              acc_done
);
   import dram_seq_pkg::*;

   localparam logic [GAP_W-1:0] RCD_M1 = GAP_W'(T_RCD - 1);
   localparam logic [GAP_W-1:0] RP_M1  = GAP_W'(T_RP - 1);

   if (T_RCD < 1 || T_RCD > 200) begin : g_bad_rcd
      $error("dram_seq: T_RCD out of range 1..200");
   end
   if (T_RP < 1 || T_RP > 200) begin : g_bad_rp
      $error("dram_seq: T_RP out of range 1..200");
   end
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_geom
      $error("dram_seq: row and column widths must be positive");
   end

   seq_st_t           st, tgt;
   logic [GAP_W-1:0]  cnt;
   logic              rf_mode;
   logic [ADDR_W-1:0] lat_addr;
   logic [ROW_W-1:0]  lat_row, rq_row, rf_ptr;
   logic [COL_W-1:0]  lat_col;
   logic              rf_pend, rf_grant, open_vld, hit;

   assign lat_row  = lat_addr[ADDR_W-1:COL_W];
   assign lat_col  = lat_addr[COL_W-1:0];
   assign rq_row   = rq_addr[ADDR_W-1:COL_W];
   assign rf_grant = (st == S_IDLE) && rf_pend;

   dram_rfsh_ctl #(.PERIOD(RFSH_PERIOD), .PTR_W(ROW_W)) u_rfsh (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (rf_grant),
      .step    (st == S_RF_ACT),
      .pending (rf_pend),
      .ptr     (rf_ptr)
   );

   dram_row_tracker #(.ROW_W(ROW_W)) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (st == S_ACT),
      .close    ((st == S_PRE) || (st == S_RF_CLS)),
      .act_row  (lat_row),
      .cmp_row  (rq_row),
      .open_vld (open_vld),
      .hit      (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         tgt      <= S_IDLE;
         cnt      <= '0;
         rf_mode  <= 1'b0;
         lat_addr <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (rf_pend) begin
                  rf_mode <= 1'b1;
                  st      <= open_vld ? S_PRE : S_RF_ACT;
               end else if (rq_valid) begin
                  rf_mode  <= 1'b0;
                  lat_addr <= rq_addr;
                  st       <= hit ? S_COL : (open_vld ? S_PRE : S_ACT);
               end
            end
            S_PRE: begin
               if (T_RP > 1) begin
                  cnt <= RP_M1;
                  tgt <= rf_mode ? S_RF_ACT : S_ACT;
                  st  <= S_WAIT;
               end else begin
                  st  <= rf_mode ? S_RF_ACT : S_ACT;
               end
            end
            S_ACT: begin
               if (T_RCD > 1) begin
                  cnt <= RCD_M1;
                  tgt <= S_COL;
                  st  <= S_WAIT;
               end else begin
                  st  <= S_COL;
               end
            end
            S_RF_ACT: begin
               if (T_RCD > 1) begin
                  cnt <= RCD_M1;
                  tgt <= S_RF_CLS;
                  st  <= S_WAIT;
               end else begin
                  st  <= S_RF_CLS;
               end
            end
            S_RF_CLS: begin
               if (T_RP > 1) begin
                  cnt <= RP_M1;
                  tgt <= S_IDLE;
                  st  <= S_WAIT;
               end else begin
                  st  <= S_IDLE;
               end
            end
            S_COL: st <= S_IDLE;
            S_WAIT: begin
               cnt <= cnt - 1'b1;
               if (cnt == 1) st <= tgt;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign rq_ready = (st == S_IDLE) && !rf_pend;
   assign row_stb  = (st == S_ACT) || (st == S_RF_ACT);
   assign col_stb  = (st == S_COL);
   assign pre_stb  = (st == S_PRE) || (st == S_RF_CLS);
   assign acc_done = (st == S_COL);

   always_comb begin
      unique case (st)
         S_ACT:    mem_addr = BUS_W'(lat_row);
         S_RF_ACT: mem_addr = BUS_W'(rf_ptr);
         S_COL:    mem_addr = BUS_W'(lat_col);
         default:  mem_addr = '0;
      endcase
   end

   // gap checkers: saturating distance since the last strobe of each kind
   logic [GAP_W-1:0] since_act, since_pre;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '1;
         since_pre <= '1;
      end else begin
         if (row_stb) since_act <= GAP_W'(1);
         else if (since_act != '1) since_act <= since_act + 1'b1;
         if (pre_stb) since_pre <= GAP_W'(1);
         else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      end
   end

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({row_stb, col_stb, pre_stb}));
   assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      col_stb |-> (since_act >= GAP_W'(T_RCD)));
   assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      row_stb |-> (since_pre >= GAP_W'(T_RP)));
   assert_col_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      col_stb |-> open_vld);
endmodule

// File: tb/dram_seq_bench.sv
module dram_seq_bench;
   localparam int ROW_W = 8;
   localparam int COL_W = 10;
   localparam int T_RCD = 3;
   localparam int T_RP  = 2;
   localparam int RFP   = 64;
   localparam int AW    = ROW_W + COL_W;
   localparam int BW    = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rq_valid = 1'b0;
   logic [AW-1:0] rq_addr = '0;
   logic          rq_ready, row_stb, col_stb, pre_stb, acc_done;
   logic [BW-1:0] mem_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int exp_ptr = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
              .RFSH_PERIOD(RFP)) u_dram_seq (
      .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_addr(rq_addr),
      .rq_ready(rq_ready), .mem_addr(mem_addr), .row_stb(row_stb),
      .col_stb(col_stb), .pre_stb(pre_stb), .acc_done(acc_done));

   function automatic logic [AW-1:0] mk(int row, int col);
      return {ROW_W'(row), COL_W'(col)};
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   // walk n cycles from the current negedge; offsets of -1 mean "never"
   task automatic watch(int n, int t_pre, int t_ras, int t_cas, int t_pre2,
                        int t_rdy, int ras_a, int cas_a, int inj,
                        logic [AW-1:0] inj_addr, string req);
      for (int i = 0; i < n; i++) begin
         if (i == inj) begin
            rq_valid = 1'b1;
            rq_addr  = inj_addr;
         end else if (i == inj + 1) begin
            rq_valid = 1'b0;
         end
         chk(row_stb == (i == t_ras), {req, " row_stb"}, row_stb, i == t_ras);
         chk(col_stb == (i == t_cas), {req, " col_stb"}, col_stb, i == t_cas);
         chk(pre_stb == (i == t_pre || i == t_pre2), {req, " pre_stb"}, pre_stb,
             i == t_pre || i == t_pre2);
         chk(acc_done == (i == t_cas), {req, "/R6 acc_done"}, acc_done, i == t_cas);
         if (i == t_ras) chk(mem_addr == BW'(ras_a), {req, "/R2 row addr"}, mem_addr, ras_a);
         else if (i == t_cas) chk(mem_addr == BW'(cas_a), {req, "/R2 col addr"}, mem_addr, cas_a);
         else chk(mem_addr == '0, {req, "/R2 idle addr"}, mem_addr, 0);
         if (t_rdy >= 0) chk(rq_ready == (i >= t_rdy), {req, "/R6 ready"}, rq_ready, i >= t_rdy);
         @(negedge clk);
      end
   endtask

   task automatic send(logic [AW-1:0] a, string req);
      chk(rq_ready == 1'b1, {req, " ready before request"}, rq_ready, 1);
      rq_valid = 1'b1;
      rq_addr  = a;
      @(negedge clk);
      rq_valid = 1'b0;
   endtask

   task automatic wait_strobe(bit want_pre, string req);
      int k = 0;
      while (!(want_pre ? pre_stb : row_stb) && k < 4 * RFP) begin
         @(negedge clk);
         k++;
      end
      chk(k < 4 * RFP, {req, " refresh seen"}, k, 0);
   endtask

   task automatic t_reset();
      chk(rq_ready == 1'b1, "R1 ready in reset", rq_ready, 1);
      chk({row_stb, col_stb, pre_stb, acc_done} == 4'b0, "R1 strobes in reset",
          {row_stb, col_stb, pre_stb, acc_done}, 0);
      chk(mem_addr == '0, "R1 addr in reset", mem_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rq_ready == 1'b1, "R1 ready after reset", rq_ready, 1);
      chk({row_stb, col_stb, pre_stb, acc_done} == 4'b0, "R1 strobes after reset",
          {row_stb, col_stb, pre_stb, acc_done}, 0);
   endtask

   task automatic t_closed();   // R3
      send(mk(8'h05, 10'h03A), "R3");
      watch(6, -1, 0, T_RCD, -1, T_RCD + 1, 8'h05, 10'h03A, -1, '0, "R3");
   endtask

   task automatic t_hit();      // R4
      send(mk(8'h05, 10'h2D5), "R4");
      watch(3, -1, -1, 0, -1, 1, 0, 10'h2D5, -1, '0, "R4");
   endtask

   task automatic t_miss();     // R5
      send(mk(8'h9C, 10'h007), "R5");
      watch(8, 0, T_RP, T_RP + T_RCD, -1, T_RP + T_RCD + 1, 8'h9C, 10'h007, -1, '0, "R5");
   endtask

   task automatic t_ignore();   // R7: valid pulse during busy leaves no trace
      send(mk(8'h21, 10'h155), "R7");
      watch(12, 0, T_RP, T_RP + T_RCD, -1, T_RP + T_RCD + 1, 8'h21, 10'h155,
            1, mk(8'h21, 10'h001), "R7");
   endtask

   task automatic t_rf_open();  // R8 with a row open
      wait_strobe(1'b1, "R8");
      watch(9, 0, T_RP, -1, T_RP + T_RCD, 2 * T_RP + T_RCD, exp_ptr, 0, -1, '0, "R8 open");
      exp_ptr++;
   endtask

   task automatic t_rf_closed_then_req();  // R8 with no row, then row stays closed
      wait_strobe(1'b0, "R8");
      watch(6, -1, 0, -1, T_RCD, T_RCD + T_RP, exp_ptr, 0, -1, '0, "R8 closed");
      exp_ptr++;
      send(mk(8'h21, 10'h0F0), "R8 post");
      watch(6, -1, 0, T_RCD, -1, T_RCD + 1, 8'h21, 10'h0F0, -1, '0, "R8 post");
   endtask

   task automatic t_ptr_wrap();  // R9 pointer sequence, R8 interval
      int last = 0;
      for (int k = 0; k < 260; k++) begin
         wait_strobe(1'b0, "R9");
         chk(mem_addr == BW'(exp_ptr % (1 << ROW_W)), "R9 refresh pointer",
             mem_addr, exp_ptr % (1 << ROW_W));
         if (k >= 2) chk(cyc - last == RFP, "R8 refresh interval", cyc - last, RFP);
         last = cyc;
         exp_ptr++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_closed();
      t_hit();
      t_miss();
      t_ignore();
      t_rf_open();
      t_rf_closed_then_req();
      t_ptr_wrap();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule